// File: doc/BRIEF.md
# DRAM Burst Column Order Generator

This block turns one read or write command into the column index of each of the eight beats of a DRAM burst. It takes the mode settings: a two-bit burst-length field and a burst-type bit. It also takes a per-command chop flag, a read/write indication and the low three bits of the starting column. From these it steps through the burst one beat per clock. Each beat carries the column index, a beat-valid flag and, on reads, a flag that marks slots that carry no data and leave the data and strobe drivers in high impedance.

A command is taken by pulsing the start strobe while no burst is running. The settings are captured at that edge, so the inputs may change freely during the burst. The block also reports whether the internal write start is pulled in by two clocks, which is the case only when chop-by-four is fixed by the mode field. Data capture, strobe timing and physical I/O belong to other blocks.

Top module: `burst_col_seq`

## Requirements
- R1: With the burst-type bit at 0 (sequential), a read's beat i carries column {s2 ^ i2, (s1s0 + i1i0) mod 4}. Here s is the captured start column and i is the beat number 0..7. For example, start 5 gives 5,6,7,4,1,2,3,0.
- R2: With the burst-type bit at 1 (interleaved), a read's beat i carries column s XOR i. For example, start 5 gives 5,4,7,6,1,0,3,2.
- R3: The burst-length field is decoded as follows: 00 is fixed length 8 and 10 is fixed chop-4. 01 selects per command, where the chop flag at 1 means chop-4 and at 0 means length 8. 11 is reserved and behaves as 00.
- R4: A chop-4 read follows the selected order on beats 0..3. On beats 4..7 it raises beat_hiz, while the column output continues the same order as a length-8 burst. beat_hiz is 0 on every other beat and while idle.
- R5: A chop-4 write carries column {s2 ^ i2, i1i0}: 0,1,2,3 when s2 is 0 and 4,5,6,7 when s2 is 1. The low two start bits and the burst type have no effect, and beat_hiz stays 0.
- R6: A length-8 write carries column i on beat i (0 through 7), whatever the start column and burst type.
- R7: wr_advance is 1 on every beat of a write accepted while the field is 10 (fixed chop-4). It is 0 for on-the-fly chop writes, for reads, for length-8 writes and while idle.
- R8: An accepted start gives beat_vld high for exactly eight consecutive cycles, beginning with the cycle after the accepting edge. While beat_vld is low, beat_col is 0.
- R9: A start pulse during any cycle in which beat_vld is high is ignored. This holds on the last beat as well: the running burst keeps its order and ends on time, and no new burst follows.
- R10: A synchronous active-low reset ends any burst. In the following cycle beat_vld, beat_hiz and wr_advance are 0 and beat_col is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bl_mode | input | 2 | Burst-length mode field (R3 encoding) |
| burst_ilv | input | 1 | Burst type: 0 sequential, 1 interleaved |
| otf_chop | input | 1 | Per-command chop select, 1 = chop-4 (used in on-the-fly mode) |
| is_write | input | 1 | 1 = write command, 0 = read command |
| start_col | input | 3 | Low three bits of the starting column |
| start | input | 1 | Command strobe, one cycle |
| beat_col | output | 3 | Column index of the current beat |
| beat_vld | output | 1 | Beat is active |
| beat_hiz | output | 1 | Read slot with no data; drivers in high impedance |
| wr_advance | output | 1 | Internal write start is pulled in by two clocks |

## Verification
The hardest situation to reach is a start pulse that coincides with the final beat. That is the edge at which the counter retires, and a careless design would treat the block as free and launch a second burst there. The bench holds start high exactly while beat 7 is shown, then checks that beat_vld falls the next cycle and stays low. It also injects a start with a different column in the middle of another burst and checks that the order is unchanged. A reset in the middle of a burst, and the reserved mode code running a length-8 order, are driven as their own scenarios.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  localparam int COL_W = 3;

  typedef enum logic [1:0] {
    BLM_FIX8 = 2'b00,
    BLM_OTF  = 2'b01,
    BLM_FIX4 = 2'b10,
    BLM_RSVD = 2'b11
  } blm_e;

  typedef struct packed {
    logic             rd;
    logic             ilv;
    logic             chop;
    logic             adv;
    logic [COL_W-1:0] col0;
  } burst_cmd_t;

  // chop-4 decision from the mode field and the per-command flag
  function automatic logic decide_chop(input logic [1:0] mode, input logic otf);
    case (blm_e'(mode))
      BLM_FIX4: decide_chop = 1'b1;
      BLM_OTF:  decide_chop = otf;
      default:  decide_chop = 1'b0;
    endcase
  endfunction

  // sequential: keep low-pair rotation, flip the top bit in the second half
  function automatic logic [COL_W-1:0] seq_col(input logic [COL_W-1:0] s,
                                               input logic [COL_W-1:0] i);
    logic [1:0] lo;
    lo = s[1:0] + i[1:0];
    seq_col = {s[2] ^ i[2], lo};
  endfunction

  function automatic logic [COL_W-1:0] ilv_col(input logic [COL_W-1:0] s,
                                               input logic [COL_W-1:0] i);
    ilv_col = s ^ i;
  endfunction

  // write: chop keeps only the top start bit, length 8 ignores the start
  function automatic logic [COL_W-1:0] wr_col(input logic [COL_W-1:0] s,
                                              input logic [COL_W-1:0] i,
                                              input logic             chop);
    wr_col = chop ? {s[2] ^ i[2], i[1:0]} : i;
  endfunction

endpackage

// File: rtl/burst_cmd_latch.sv
module burst_cmd_latch
  import burst_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [1:0]       bl_mode,
  input  logic             burst_ilv,
  input  logic             otf_chop,
  input  logic             is_write,
  input  logic [COL_W-1:0] start_col,
  output burst_cmd_t       cmd_q
);

  burst_cmd_t cmd_d;

  always_comb begin
    cmd_d.rd   = ~is_write;
    cmd_d.ilv  = burst_ilv;
    cmd_d.chop = decide_chop(bl_mode, otf_chop);
    cmd_d.adv  = is_write && (blm_e'(bl_mode) == BLM_FIX4);
    cmd_d.col0 = start_col;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      cmd_q <= '0;
    else if (accept) cmd_q <= cmd_d;
  end

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int BEATS  = 8,
  localparam int BEAT_W = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              accept,
  output logic              active,
  output logic              last,
  output logic [BEAT_W-1:0] cnt
);

  localparam logic [BEAT_W-1:0] LAST_IDX = BEAT_W'(BEATS - 1);

  assign accept = start && !active;
  assign last   = active && (cnt == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (accept) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (active) begin
      cnt <= last ? '0 : cnt + 1'b1;
      if (last) active <= 1'b0;
    end
  end

endmodule

// File: rtl/burst_col_map.sv
module burst_col_map
  import burst_seq_pkg::*;
#(
  parameter int BEATS = 8,
  localparam int BEAT_W = $clog2(BEATS)
) (
  input  logic              active,
  input  burst_cmd_t        cmd,
  input  logic [BEAT_W-1:0] beat,
  output logic [COL_W-1:0]  col,
  output logic              hiz,
  output logic              adv
);

  localparam int HALF = BEATS / 2;

  logic [COL_W-1:0] idx;
  logic [COL_W-1:0] rd_col;
  logic             upper_half;

  assign idx        = COL_W'(beat);
  assign upper_half = (int'(beat) >= HALF);
  assign rd_col     = cmd.ilv ? ilv_col(cmd.col0, idx) : seq_col(cmd.col0, idx);

  always_comb begin
    col = '0;
    hiz = 1'b0;
    adv = 1'b0;
    if (active) begin
      col = cmd.rd ? rd_col : wr_col(cmd.col0, idx, cmd.chop);
      hiz = cmd.rd && cmd.chop && upper_half;
      adv = cmd.adv;
    end
  end

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_seq_pkg::*;
#(
  parameter int BEATS = 8,
  localparam int BEAT_W = $clog2(BEATS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       bl_mode,
  input  logic             burst_ilv,
  input  logic             otf_chop,
  input  logic             is_write,
  input  logic [COL_W-1:0] start_col,
  input  logic             start,
  output logic [COL_W-1:0] beat_col,
  output logic             beat_vld,
  output logic             beat_hiz,
  output logic             wr_advance
);

  // named internal events, used by the bound checker
  logic              accept_w;
  logic              active_w;
  logic              last_w;
  logic [BEAT_W-1:0] cnt_w;
  burst_cmd_t        cmd_w;

  burst_beat_ctr #(.BEATS(BEATS)) u_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .accept (accept_w),
    .active (active_w),
    .last   (last_w),
    .cnt    (cnt_w)
  );

  burst_cmd_latch u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept_w),
    .bl_mode   (bl_mode),
    .burst_ilv (burst_ilv),
    .otf_chop  (otf_chop),
    .is_write  (is_write),
    .start_col (start_col),
    .cmd_q     (cmd_w)
  );

  burst_col_map #(.BEATS(BEATS)) u_map (
    .active (active_w),
    .cmd    (cmd_w),
    .beat   (cnt_w),
    .col    (beat_col),
    .hiz    (beat_hiz),
    .adv    (wr_advance)
  );

  assign beat_vld = active_w;

endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
  parameter int BEAT_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              accept_w,
  input logic              last_w,
  input logic [BEAT_W-1:0] cnt_w,
  input logic              rd_q,
  input logic              ilv_q,
  input logic              chop_q,
  input logic [2:0]        beat_col,
  input logic              beat_vld,
  input logic              beat_hiz,
  input logic              wr_advance
);

  // R8: accepted start opens a burst at beat 0
  assert_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> (beat_vld && cnt_w == '0));

  // R8: beats advance by one while not on the last beat
  assert_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_vld && !last_w) |=> (beat_vld && cnt_w == $past(cnt_w) + 1'b1));

  // R8, R9: burst closes after the last beat, even with start present
  assert_close_R9: assert property (@(posedge clk) disable iff (!rst_n)
    last_w |=> !beat_vld);

  // R9: no command is taken while a burst runs
  assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && beat_vld) |-> !accept_w);

  // R4: high impedance only on the second half of a chopped read
  assert_hiz_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    beat_hiz |-> (beat_vld && rd_q && chop_q && cnt_w[BEAT_W-1]));

  // R7: write advance only within a write burst
  assert_adv_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_advance |-> (beat_vld && !rd_q));

  // R1: sequential read keeps the top bit inside each half
  assert_seq_half_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_vld && rd_q && !ilv_q && cnt_w != 3'd3 && !last_w)
      |=> (beat_col[2] == $past(beat_col[2])));

  // R8: idle column is zero
  assert_idle_col_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_vld |-> (beat_col == 3'd0 && !beat_hiz && !wr_advance));

  // R10: reset clears all outputs on the next cycle
  assert_reset_R10: assert property (@(posedge clk)
    !rst_n |=> (!beat_vld && !beat_hiz && !wr_advance && beat_col == 3'd0));

endmodule

bind burst_col_seq burst_col_seq_chk #(.BEAT_W(BEAT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .accept_w   (accept_w),
  .last_w     (last_w),
  .cnt_w      (cnt_w),
  .rd_q       (cmd_w.rd),
  .ilv_q      (cmd_w.ilv),
  .chop_q     (cmd_w.chop),
  .beat_col   (beat_col),
  .beat_vld   (beat_vld),
  .beat_hiz   (beat_hiz),
  .wr_advance (wr_advance)
);

// File: tb/burst_col_seq_tb.sv
module burst_col_seq_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] bl_mode;
  logic       burst_ilv;
  logic       otf_chop;
  logic       is_write;
  logic [2:0] start_col;
  logic       start;
  logic [2:0] beat_col;
  logic       beat_vld;
  logic       beat_hiz;
  logic       wr_advance;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  burst_col_seq u_dut (
    .clk(clk), .rst_n(rst_n), .bl_mode(bl_mode), .burst_ilv(burst_ilv),
    .otf_chop(otf_chop), .is_write(is_write), .start_col(start_col),
    .start(start), .beat_col(beat_col), .beat_vld(beat_vld),
    .beat_hiz(beat_hiz), .wr_advance(wr_advance)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // expected column, written from the requirement text
  function automatic int exp_col(bit rd, bit ilv, bit chop, int s, int i);
    int half;
    if (!rd) begin
      if (!chop) return i;
      return (s >= 4) ? ((i + 4) % 8) : i;
    end
    if (ilv) return s ^ i;
    half = (i < 4) ? (s / 4) : (1 - s / 4);
    return half * 4 + ((s % 4) + i) % 4;
  endfunction

  task automatic idle_check(input string req);
    chk(req, "idle vld", beat_vld, 0);
    chk(req, "idle col", beat_col, 0);
    chk(req, "idle hiz", beat_hiz, 0);
    chk(req, "idle adv", wr_advance, 0);
  endtask

  // runs one burst; inject_at >= 0 raises start during that beat
  task automatic run_burst(input string req, input int mode, input bit ilv,
                           input bit otf, input bit wr, input int s,
                           input int inject_at);
    bit chop;
    bit adv;
    chop = (mode == 2) || (mode == 1 && otf);
    adv  = wr && (mode == 2);
    @(negedge clk);
    bl_mode = 2'(mode); burst_ilv = ilv; otf_chop = otf;
    is_write = wr; start_col = 3'(s); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // scramble inputs; the captured command must hold
    bl_mode = 2'(3 - mode); burst_ilv = ~ilv; is_write = ~wr; start_col = 3'(~s);
    for (int i = 0; i < 8; i++) begin
      if (i > 0) @(negedge clk);
      start = (i == inject_at);
      chk(req, $sformatf("vld beat %0d", i), beat_vld, 1);
      chk(req, $sformatf("col beat %0d", i), beat_col, exp_col(!wr, ilv, chop, s, i));
      chk(req, $sformatf("hiz beat %0d", i), beat_hiz, (!wr && chop && i >= 4) ? 1 : 0);
      chk(req, $sformatf("adv beat %0d", i), wr_advance, adv ? 1 : 0);
    end
    @(negedge clk);
    start = 1'b0;
    idle_check(req);
    @(negedge clk);
    idle_check(req);
  endtask

  task automatic t_reset_state;  // R10
    rst_n = 1'b0; start = 1'b0; bl_mode = 2'b00; burst_ilv = 1'b0;
    otf_chop = 1'b0; is_write = 1'b0; start_col = 3'd0;
    repeat (3) @(negedge clk);
    idle_check("R10");
    rst_n = 1'b1;
  endtask

  task automatic t_seq_reads;  // R1
    for (int s = 0; s < 8; s++) run_burst("R1", 0, 1'b0, 1'b0, 1'b0, s, -1);
  endtask

  task automatic t_ilv_reads;  // R2
    for (int s = 0; s < 8; s++) run_burst("R2", 0, 1'b1, 1'b0, 1'b0, s, -1);
  endtask

  task automatic t_chop_reads;  // R4
    run_burst("R4", 2, 1'b0, 1'b0, 1'b0, 6, -1);
    run_burst("R4", 2, 1'b1, 1'b0, 1'b0, 3, -1);
  endtask

  task automatic t_chop_writes;  // R5, R7 fixed chop
    for (int s = 0; s < 8; s++) run_burst("R5", 2, s[0], 1'b0, 1'b1, s, -1);
  endtask

  task automatic t_bl8_writes;  // R6
    run_burst("R6", 0, 1'b0, 1'b0, 1'b1, 5, -1);
    run_burst("R6", 0, 1'b1, 1'b0, 1'b1, 7, -1);
  endtask

  task automatic t_mode_field;  // R3, R7
    run_burst("R3", 1, 1'b0, 1'b1, 1'b0, 5, -1);  // on-the-fly chop read
    run_burst("R3", 1, 1'b1, 1'b0, 1'b0, 5, -1);  // on-the-fly length 8 read
    run_burst("R7", 1, 1'b0, 1'b1, 1'b1, 6, -1);  // on-the-fly chop write, no advance
    run_burst("R3", 3, 1'b0, 1'b1, 1'b0, 2, -1);  // reserved code acts as length 8
  endtask

  task automatic t_busy_start;  // R9
    run_burst("R9", 0, 1'b0, 1'b0, 1'b0, 1, 3);  // mid-burst start
    run_burst("R9", 0, 1'b1, 1'b0, 1'b0, 4, 7);  // start on last beat
  endtask

  task automatic t_reset_mid;  // R10
    @(negedge clk);
    bl_mode = 2'b00; burst_ilv = 1'b0; is_write = 1'b0; start_col = 3'd2; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10", "vld before reset", beat_vld, 1);
    rst_n = 1'b0;
    @(negedge clk);
    idle_check("R10");
    rst_n = 1'b1;
    @(negedge clk);
    idle_check("R10");
  endtask

  initial begin
    t_reset_state();
    t_seq_reads();
    t_ilv_reads();
    t_chop_reads();
    t_chop_writes();
    t_bl8_writes();
    t_mode_field();
    t_busy_start();
    t_reset_mid();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule